// File: doc/BRIEF.md
# Burst-Framed Asynchronous Serial Transmitter

This block drives one serial line with an asynchronous framing built for bursts. The line rests at mark. A single space bit opens a burst. Characters that are ready in time follow each other with no framing bits at all. When no character is waiting at a character boundary, the block holds mark for a fixed number of bit-times. That run lets a receiver see the line go idle before any later start bit.

To guarantee edges inside long bursts, the block adds one complement bit after an all-ones or an all-zeros character. A user can also request a line break, which is a long space of configurable length. A user can also request a status-escape prefix, which is a reserved run of bits that a receiver can tell apart from any stuffed data character. All timing is counted in periods of an external bit-rate tick.

Characters enter through a valid/ready stream. Break and escape requests are single-cycle pulses that the block holds until it can serve them.

Top module: `burst_serial_tx`

## Requirements
- R1: After reset and whenever no burst, break or idle run is in progress, the line is at mark (1). The first bit of every burst is one space (0) bit-time.
- R2: Characters accepted one after another within a burst follow each other with no bits between them, except the stuffed bits of R4 and R5.
- R3: Each character is sent least significant bit first. Each bit lasts exactly one bit-tick period. The line changes only on a clock edge where the tick is high.
- R4: A character of all ones (0xFF) is followed directly by one 0 bit.
- R5: A character of all zeros (0x00) is followed directly by one 1 bit.
- R6: When no character or escape is pending at a character boundary, the line holds mark for exactly 9 bit-times. A start bit can come on the 10th bit-time at the earliest.
- R7: An escape request is sent as 8 zero bits, then a 0 bit, then a 1 bit. If it starts a burst, it is preceded by a start bit. Inside a burst it has no start bit. At a boundary it takes priority over a valid character.
- R8: A break drives space for max(brk_len, 12) bit-times, followed by the 9-bit mark run of R6.
- R9: A break starts only from the idle line. A request made during a burst waits until the burst and its 9 mark bit-times have ended.
- R10: in_ready is high only in a cycle where bit_tick is high and the block is at a point where it can accept a character. A character is taken when in_valid and in_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit-time |
| in_valid | input | 1 | Character available |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Character accepted this cycle when in_valid is high |
| brk_req | input | 1 | Pulse requesting a break |
| brk_len | input | 16 | Break length in bit-times (values below 12 act as 12) |
| esc_req | input | 1 | Pulse requesting a status-escape prefix |
| tx_line | output | 1 | Serial line, mark = 1 |

## Verification
The bench rebuilds each expected bit stream from the requirements and compares it bit by bit. It covers the following corner cases and the failure each one exposes:
- Stuffing: 0xFF and 0x00 characters inside bursts. A design that drops or inverts the stuffed bit leaves an edgeless run, or shifts every later character by one bit.
- Idle gap: a character that arrives during the mark run must start exactly on the tenth bit-time. A design that cuts the gap short, or merges the character into the old burst, fails the bit comparison.
- Escape prefix: sent both from idle and mid-burst. A design that inserts a start bit inside the burst, or lets data win over the escape, shows up as misplaced bits.
- Break: one break request arrives during a burst, and one uses a length below the minimum. These catch a break that cuts into data and a missing clamp.

// File: rtl/burst_serial_tx.sv
module burst_serial_tx #(
  parameter int DATA_W   = 8,
  parameter int GAP_BITS = 9,
  parameter int BRK_MIN  = 12,
  parameter int LEN_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              brk_req,
  input  logic [LEN_W-1:0]  brk_len,
  input  logic              esc_req,
  output logic              tx_line
);
  localparam int SEQ_W = DATA_W + 2;
  localparam int CNT_W = $clog2(SEQ_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_TAIL, S_BRK} state_t;

  state_t           state;
  logic [SEQ_W-1:0] seq_q;
  logic [CNT_W-1:0] left_q;
  logic [LEN_W-1:0] cnt_q;
  logic             tx_q, brk_pend, esc_pend;

  wire can_start = (state == S_IDLE) || (state == S_TAIL && cnt_q == '0);
  wire boundary  = (state == S_SEND) && (left_q == '0);
  wire all_one   = &in_data;
  wire all_zero  = ~|in_data;

  wire [SEQ_W-1:0] seq_dat = {1'b0, ~all_one, in_data};
  wire [SEQ_W-1:0] seq_esc = {1'b1, 1'b0, {DATA_W{1'b0}}};
  wire [SEQ_W-1:0] nxt_seq = esc_pend ? seq_esc : seq_dat;
  wire [CNT_W-1:0] nxt_len = esc_pend ? CNT_W'(SEQ_W)
                           : (all_one || all_zero) ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);
  wire [LEN_W-1:0] brk_eff = (brk_len < LEN_W'(BRK_MIN)) ? LEN_W'(BRK_MIN) : brk_len;

  assign in_ready = bit_tick && !esc_pend && ((can_start && !brk_pend) || boundary);
  assign tx_line  = tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      seq_q    <= '0;
      left_q   <= '0;
      cnt_q    <= '0;
      tx_q     <= 1'b1;
      brk_pend <= 1'b0;
      esc_pend <= 1'b0;
    end else begin
      if (bit_tick) begin
        if (can_start) begin
          if (brk_pend) begin
            state    <= S_BRK;
            tx_q     <= 1'b0;
            cnt_q    <= brk_eff - 1'b1;
            brk_pend <= 1'b0;
          end else if (esc_pend || in_valid) begin
            state    <= S_SEND;
            tx_q     <= 1'b0;
            seq_q    <= nxt_seq;
            left_q   <= nxt_len;
            esc_pend <= 1'b0;
          end else if (state == S_TAIL) begin
            state <= S_IDLE;
          end
        end else begin
          case (state)
            S_SEND: begin
              if (left_q != '0) begin
                tx_q   <= seq_q[0];
                seq_q  <= seq_q >> 1;
                left_q <= left_q - 1'b1;
              end else if (esc_pend || in_valid) begin
                tx_q     <= nxt_seq[0];
                seq_q    <= nxt_seq >> 1;
                left_q   <= nxt_len - 1'b1;
                esc_pend <= 1'b0;
              end else begin
                state <= S_TAIL;
                tx_q  <= 1'b1;
                cnt_q <= LEN_W'(GAP_BITS - 1);
              end
            end
            S_TAIL: cnt_q <= cnt_q - 1'b1;
            S_BRK: begin
              if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
              end else begin
                state <= S_TAIL;
                tx_q  <= 1'b1;
                cnt_q <= LEN_W'(GAP_BITS - 1);
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
      if (esc_req) esc_pend <= 1'b1;
      if (brk_req) brk_pend <= 1'b1;
    end
  end

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> tx_line); // R1
  AST_TICK_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_line)); // R3
  AST_GAP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_TAIL |-> tx_line); // R6
  AST_BRK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_BRK |-> !tx_line); // R8
  AST_BRK_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BRK && $past(state) != S_BRK) |-> $past(can_start)); // R9
  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_tick); // R10
endmodule

// File: tb/burst_serial_tx_tb.sv
`timescale 1ns/1ps
module burst_serial_tx_tb;
  logic        clk = 0, rst_n = 0, bit_tick = 0, tick_d = 0;
  logic        brk_req = 0, esc_req = 0;
  logic [15:0] brk_len = 16'd12;
  logic [1:0]  div = 0;
  logic        in_ready, tx_line, in_valid;
  logic [7:0]  in_data;
  logic [7:0]  fq [0:63];
  int          acc_idx = 0, fend = 0;
  logic        rec [0:4095];
  int          rn = 0, rbase = 0;
  int          checks = 0, errors = 0, ready_bad = 0;
  bit          exp_q [$];

  always #2.5 clk = ~clk;

  burst_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .brk_req(brk_req),
    .brk_len(brk_len), .esc_req(esc_req), .tx_line(tx_line));

  assign in_valid = acc_idx < fend;
  assign in_data  = fq[acc_idx & 63];

  always @(negedge clk) begin
    div      <= div + 2'd1;
    bit_tick <= (div == 2'd3);
  end
  always @(posedge clk) begin
    tick_d <= bit_tick;
    if (in_valid && in_ready) acc_idx <= acc_idx + 1;
  end
  always @(negedge clk) begin
    if (tick_d) begin
      rec[rn & 4095] <= tx_line;
      rn <= rn + 1;
    end
    if (in_ready && !bit_tick) ready_bad <= ready_bad + 1;
  end

  task automatic wait_ticks(input int n);
    repeat (4 * n) @(negedge clk);
  endtask

  task automatic feed(input logic [7:0] b);
    fq[fend & 63] = b;
    fend = fend + 1;
  endtask

  task automatic add_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    if (b == 8'hFF) exp_q.push_back(1'b0);
    if (b == 8'h00) exp_q.push_back(1'b1);
  endtask

  task automatic add_bits(input bit v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  task automatic pulse_esc();
    @(negedge clk) esc_req = 1;
    @(negedge clk) esc_req = 0;
  endtask

  task automatic pulse_brk();
    @(negedge clk) brk_req = 1;
    @(negedge clk) brk_req = 0;
  endtask

  task automatic begin_case();
    exp_q.delete();
    @(negedge clk);
    rbase = rn;
  endtask

  task automatic check_stream(input string req);
    int k, bad, ones;
    k = -1;
    bad = -1;
    for (int i = rbase; i < rn; i++) if (rec[i & 4095] == 1'b0) begin k = i; break; end
    checks++;
    if (k < 0) begin
      errors++;
      $display("FAIL %s: no start seen, got all-mark expected a space", req);
      return;
    end
    for (int i = 0; i < exp_q.size(); i++)
      if (rec[(k + i) & 4095] !== exp_q[i]) begin bad = i; break; end
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: bit %0d got %0b expected %0b", req, bad,
               rec[(k + bad) & 4095], exp_q[bad]);
    end
    ones = 0;
    for (int i = k + exp_q.size(); i < rn; i++) begin
      if (rec[i & 4095] != 1'b1) break;
      ones++;
    end
    checks++;
    if (ones < 9) begin
      errors++;
      $display("FAIL R6 (%s): trailing mark run got %0d expected >= 9", req, ones);
    end
  endtask

  task automatic t_reset();
    checks++;
    if (tx_line !== 1'b1) begin
      errors++;
      $display("FAIL R1: line after reset got %0b expected 1", tx_line);
    end
  endtask

  task automatic t_single();
    begin_case();
    exp_q.push_back(0); add_byte(8'hA5);
    feed(8'hA5);
    wait_ticks(40);
    check_stream("R1/R3 single 0xA5");
  endtask

  task automatic t_burst();
    begin_case();
    exp_q.push_back(0); add_byte(8'h3C); add_byte(8'h5A); add_byte(8'h81);
    feed(8'h3C); feed(8'h5A); feed(8'h81);
    wait_ticks(60);
    check_stream("R2 burst of three");
  endtask

  task automatic t_ones();
    begin_case();
    exp_q.push_back(0); add_byte(8'hFF); add_byte(8'h12); add_byte(8'hFF);
    feed(8'hFF); feed(8'h12); feed(8'hFF);
    wait_ticks(60);
    check_stream("R4 all-ones stuffing");
  endtask

  task automatic t_zeros();
    begin_case();
    exp_q.push_back(0); add_byte(8'h00); add_byte(8'h00); add_byte(8'h80);
    feed(8'h00); feed(8'h00); feed(8'h80);
    wait_ticks(60);
    check_stream("R5 all-zeros stuffing");
  endtask

  task automatic t_gap();
    begin_case();
    exp_q.push_back(0); add_byte(8'hC3); add_bits(1, 9);
    exp_q.push_back(0); add_byte(8'h7E);
    feed(8'hC3);
    wait (acc_idx == fend);
    wait_ticks(11);
    feed(8'h7E);
    wait_ticks(50);
    check_stream("R6 exact idle gap");
  endtask

  task automatic t_esc_idle();
    begin_case();
    exp_q.push_back(0); add_bits(0, 9); add_bits(1, 1);
    pulse_esc();
    wait_ticks(40);
    check_stream("R7 escape from idle");
  endtask

  task automatic t_esc_prio();
    begin_case();
    exp_q.push_back(0); add_bits(0, 9); add_bits(1, 1); add_byte(8'h41);
    @(negedge clk);
    while (bit_tick) @(negedge clk);
    esc_req = 1;
    feed(8'h41);
    @(negedge clk) esc_req = 0;
    wait_ticks(50);
    check_stream("R7 escape before data");
  endtask

  task automatic t_esc_mid();
    begin_case();
    exp_q.push_back(0); add_byte(8'h0F); add_bits(0, 9); add_bits(1, 1); add_byte(8'h33);
    feed(8'h0F); feed(8'h33);
    wait (acc_idx == fend - 1);
    pulse_esc();
    wait_ticks(60);
    check_stream("R7 escape mid-burst");
  endtask

  task automatic t_break(input logic [15:0] len, input int eff);
    begin_case();
    brk_len = len;
    add_bits(0, eff);
    pulse_brk();
    wait_ticks(eff + 30);
    check_stream(len < 12 ? "R8 break clamped to 12" : "R8 break length");
  endtask

  task automatic t_break_burst();
    begin_case();
    brk_len = 16'd12;
    exp_q.push_back(0); add_byte(8'h55); add_byte(8'hAA); add_bits(1, 9); add_bits(0, 12);
    feed(8'h55); feed(8'hAA);
    wait (acc_idx == fend - 1);
    pulse_brk();
    wait_ticks(70);
    check_stream("R9 break deferred past burst");
  endtask

  task automatic t_handshake();
    checks++;
    if (acc_idx != fend) begin
      errors++;
      $display("FAIL R10: characters taken got %0d expected %0d", acc_idx, fend);
    end
    checks++;
    if (ready_bad != 0) begin
      errors++;
      $display("FAIL R10: ready without tick got %0d expected 0", ready_bad);
    end
  endtask

  initial begin
    repeat (6) @(negedge clk);
    rst_n = 1;
    wait_ticks(12);
    t_reset();
    t_single();
    t_burst();
    t_ones();
    t_zeros();
    t_gap();
    t_esc_idle();
    t_esc_prio();
    t_esc_mid();
    t_break(16'd20, 20);
    t_break(16'd5, 12);
    t_break_burst();
    t_handshake();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run got no end expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule